// File: doc/BRIEF.md
# Fetch Address Chooser with Taken-Jump Prediction

This block sits in the fetch stage of a five-stage in-order pipeline. Every cycle it decides which address the instruction memory should read. It also keeps a guess of the address that follows the instruction now being fetched. That guess is held in a register that belongs to the fetch stage.

The guess is simple. Any jump, conditional or not, and any call is assumed to go to its destination constant. All other instructions are assumed to fall through to the incremented address. A return instruction gets no target guess.

Later stages correct wrong guesses. A conditional jump that reaches the memory stage with its branch flag clear was guessed wrongly. Fetch then restarts at the fall-through address carried with that jump. A return that reaches write-back supplies its true target from the value it read from memory. When neither correction applies, fetch uses the stored guess.

Top module: `npc_unit`

## Requirements
- R1: When the fetched opcode is jump (4'h7) or call (4'h8) and stall is low, the predicted-PC register loads the fetched constant field at the next rising clock edge.
- R2: When the fetched opcode is any other value, including return (4'h9), and stall is low, the predicted-PC register loads the fetched incremented PC at the next rising clock edge.
- R3: While reset (active low) is asserted, the predicted-PC register holds the reset vector 0.
- R4: While stall is high, the predicted-PC register keeps its value across the clock edge, whatever the fetch-stage inputs are.
- R5: When the memory-stage opcode is jump (4'h7) and its branch flag is 0, the fetch PC equals the memory-stage fall-through value in the same cycle.
- R6: When the R5 condition is false and the write-back opcode is return (4'h9), the fetch PC equals the write-back memory-read value in the same cycle.
- R7: When neither the R5 nor the R6 condition holds, the fetch PC equals the predicted-PC register.
- R8: When a mispredicted jump sits in the memory stage and a return sits in write-back in the same cycle, the fall-through value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds the predicted-PC register when high |
| f_op | input | 4 | Opcode of the instruction being fetched |
| f_const | input | 32 | Constant (destination) field of the fetched instruction |
| f_inc | input | 32 | Incremented PC of the fetched instruction |
| m_op | input | 4 | Opcode of the memory-stage instruction |
| m_taken | input | 1 | Branch flag of the memory-stage instruction |
| m_fall | input | 32 | Memory-stage valA, which holds the fall-through address of a jump |
| w_op | input | 4 | Opcode of the write-back-stage instruction |
| w_mem | input | 32 | Value the write-back instruction read from memory |
| fetch_pc | output | 32 | Address to fetch in this cycle |
| pred_pc | output | 32 | Predicted-PC register |

## Verification
The fetch PC is combinational. It must settle in the same cycle as the memory-stage and write-back inputs and the current register value. The bench therefore drives all inputs just after a falling edge and compares the fetch PC one time step later, before the next rising edge. The predicted PC is due exactly one rising edge after the fetch-stage inputs and stall are applied. The bench's model updates its own expected value at that edge and compares the register output one step after it. This keeps stall and reset effects aligned to the edge that takes them.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 32;

  localparam logic [OP_W-1:0] OP_JUMP = 4'h7;
  localparam logic [OP_W-1:0] OP_CALL = 4'h8;
  localparam logic [OP_W-1:0] OP_RET  = 4'h9;

  typedef enum logic [1:0] {
    SRC_PRED   = 2'd0,
    SRC_RETURN = 2'd1,
    SRC_FALL   = 2'd2
  } pc_src_e;

  // True when the guess should follow the destination constant
  function automatic logic guess_taken(input logic [OP_W-1:0] op);
    return (op == OP_JUMP) || (op == OP_CALL);
  endfunction

  function automatic logic jump_missed(input logic [OP_W-1:0] op, input logic taken);
    return (op == OP_JUMP) && !taken;
  endfunction

  function automatic logic is_return(input logic [OP_W-1:0] op);
    return op == OP_RET;
  endfunction

  // Priority: missed jump, then return, then stored guess
  function automatic pc_src_e pick_source(input logic missed, input logic ret);
    if (missed) return SRC_FALL;
    else if (ret) return SRC_RETURN;
    else return SRC_PRED;
  endfunction
endpackage

// File: rtl/npc_guess.sv
module npc_guess
  import npc_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 4
) (
  input  logic [OW-1:0] op,
  input  logic [AW-1:0] const_field,
  input  logic [AW-1:0] inc_pc,
  output logic          take_const,
  output logic [AW-1:0] guess
);
  always_comb begin
    take_const = guess_taken(op);
    guess      = take_const ? const_field : inc_pc;
  end
endmodule

// File: rtl/npc_hold_reg.sv
module npc_hold_reg #(
  parameter int          AW        = 32,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  localparam logic [AW-1:0] RV = AW'(RESET_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RV;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 4
) (
  input  logic [OW-1:0] m_op,
  input  logic          m_taken,
  input  logic [AW-1:0] m_fall,
  input  logic [OW-1:0] w_op,
  input  logic [AW-1:0] w_mem,
  input  logic [AW-1:0] pred,
  output logic          missed_evt,
  output logic          ret_evt,
  output pc_src_e       src,
  output logic [AW-1:0] pc
);
  always_comb begin
    missed_evt = jump_missed(m_op, m_taken);
    ret_evt    = is_return(w_op);
    src        = pick_source(missed_evt, ret_evt);
    unique case (src)
      SRC_FALL:   pc = m_fall;
      SRC_RETURN: pc = w_mem;
      default:    pc = pred;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          OW        = 4,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [OW-1:0] f_op,
  input  logic [AW-1:0] f_const,
  input  logic [AW-1:0] f_inc,
  input  logic [OW-1:0] m_op,
  input  logic          m_taken,
  input  logic [AW-1:0] m_fall,
  input  logic [OW-1:0] w_op,
  input  logic [AW-1:0] w_mem,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] pred_pc
);
  logic          take_const;
  logic [AW-1:0] next_guess;
  logic          missed_evt;
  logic          ret_evt;
  pc_src_e       src;

  npc_guess #(.AW(AW), .OW(OW)) guess_i (
    .op(f_op), .const_field(f_const), .inc_pc(f_inc),
    .take_const(take_const), .guess(next_guess)
  );

  npc_hold_reg #(.AW(AW), .RESET_VEC(RESET_VEC)) preg_i (
    .clk(clk), .rst_n(rst_n), .hold(stall), .d(next_guess), .q(pred_pc)
  );

  npc_select #(.AW(AW), .OW(OW)) sel_i (
    .m_op(m_op), .m_taken(m_taken), .m_fall(m_fall),
    .w_op(w_op), .w_mem(w_mem), .pred(pred_pc),
    .missed_evt(missed_evt), .ret_evt(ret_evt), .src(src), .pc(fetch_pc)
  );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int AW = 32,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic [OW-1:0] f_op,
  input logic [AW-1:0] f_const,
  input logic [AW-1:0] f_inc,
  input logic [OW-1:0] m_op,
  input logic          m_taken,
  input logic [AW-1:0] m_fall,
  input logic [OW-1:0] w_op,
  input logic [AW-1:0] w_mem,
  input logic [AW-1:0] fetch_pc,
  input logic [AW-1:0] pred_pc,
  input logic          missed_evt,
  input logic          ret_evt
);
  // R1
  const_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && (f_op == 4'h7 || f_op == 4'h8)) |=> pred_pc == $past(f_const));
  // R2
  inc_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && f_op != 4'h7 && f_op != 4'h8) |=> pred_pc == $past(f_inc));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pred_pc));
  // R5
  fall_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missed_evt |-> fetch_pc == m_fall);
  // R6
  ret_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!missed_evt && ret_evt) |-> fetch_pc == w_mem);
  // R7
  pred_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!missed_evt && !ret_evt) |-> fetch_pc == pred_pc);
  // R8
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_op == 4'h7 && !m_taken && w_op == 4'h9) |-> fetch_pc == m_fall);
endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .f_op(f_op), .f_const(f_const),
  .f_inc(f_inc), .m_op(m_op), .m_taken(m_taken), .m_fall(m_fall),
  .w_op(w_op), .w_mem(w_mem), .fetch_pc(fetch_pc), .pred_pc(pred_pc),
  .missed_evt(missed_evt), .ret_evt(ret_evt)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        stall = 0;
  logic [3:0]  f_op = 0, m_op = 0, w_op = 0;
  logic        m_taken = 0;
  logic [31:0] f_const = 0, f_inc = 0, m_fall = 0, w_mem = 0;
  logic [31:0] fetch_pc, pred_pc;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pred = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .f_op(f_op), .f_const(f_const),
    .f_inc(f_inc), .m_op(m_op), .m_taken(m_taken), .m_fall(m_fall),
    .w_op(w_op), .w_mem(w_mem), .fetch_pc(fetch_pc), .pred_pc(pred_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, check fetch PC, clock, check register
  task automatic step(input logic st, input logic [3:0] fo, input logic [31:0] fc,
                      input logic [31:0] fi, input logic [3:0] mo, input logic mt,
                      input logic [31:0] mf, input logic [3:0] wo, input logic [31:0] wm);
    string tag;
    logic [31:0] exp_pc;
    stall = st; f_op = fo; f_const = fc; f_inc = fi;
    m_op = mo; m_taken = mt; m_fall = mf; w_op = wo; w_mem = wm;
    #1;
    if (mo == 4'h7 && mt == 1'b0) begin
      exp_pc = mf; tag = (wo == 4'h9) ? "R8" : "R5";
    end else if (wo == 4'h9) begin
      exp_pc = wm; tag = "R6";
    end else begin
      exp_pc = model_pred; tag = "R7";
    end
    check(tag, fetch_pc, exp_pc);
    @(posedge clk);
    if (st) tag = "R4";
    else if (fo == 4'h7 || fo == 4'h8) begin model_pred = fc; tag = "R1"; end
    else begin model_pred = fi; tag = "R2"; end
    #1;
    check(tag, pred_pc, model_pred);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R3: reset state
    f_op = 4'h8; f_const = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    check("R3", pred_pc, 32'h0);
    check("R7", fetch_pc, 32'h0);
    rst_n = 1;
    model_pred = 0;
    // R1 jump and call
    step(0, 4'h7, 32'h100, 32'h5, 4'h0, 0, 32'h1, 4'h0, 32'h2);
    step(0, 4'h8, 32'h240, 32'h105, 4'h0, 0, 32'h1, 4'h0, 32'h2);
    // R2 others incl. return
    step(0, 4'h9, 32'h999, 32'h241, 4'h0, 0, 32'h1, 4'h0, 32'h2);
    step(0, 4'h1, 32'h777, 32'h300, 4'h0, 0, 32'h1, 4'h0, 32'h2);
    // R4 stall hold with a jump present
    step(1, 4'h7, 32'hAAAA, 32'hBBBB, 4'h0, 0, 32'h1, 4'h0, 32'h2);
    step(1, 4'h2, 32'hCCCC, 32'hDDDD, 4'h0, 0, 32'h1, 4'h0, 32'h2);
    // R5 missed jump; taken jump falls to R7
    step(0, 4'h0, 32'h0, 32'h400, 4'h7, 0, 32'h1234, 4'h0, 32'h2);
    step(0, 4'h0, 32'h0, 32'h404, 4'h7, 1, 32'h5678, 4'h0, 32'h2);
    // R6 return in write-back
    step(0, 4'h0, 32'h0, 32'h408, 4'h3, 0, 32'h9, 4'h9, 32'hCAFE);
    // R8 both at once
    step(0, 4'h0, 32'h0, 32'h40C, 4'h7, 0, 32'hF00D, 4'h9, 32'hCAFE);
    // R5 with non-jump memory opcode and clear flag: no redirect
    step(0, 4'h8, 32'h500, 32'h410, 4'h8, 0, 32'hBAD, 4'h0, 32'h2);
    for (int i = 0; i < 300; i++)
      step(($urandom % 5) == 0, 4'($urandom % 12), $urandom, $urandom,
           4'(6 + $urandom % 5), 1'($urandom), $urandom,
           4'(7 + $urandom % 4), $urandom);
    // R3 again: asynchronous reset mid-run
    rst_n = 0; #1;
    check("R3", pred_pc, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule